// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog counter, with a single 8-bit prescaler counter that belongs to one of them at a time. A control register chooses four settings. The first is the timer's count source: the instruction-rate clock, which is one event per `clk`, or edges on an already synchronized external level. The second is which edge of that level counts. The third is whether the prescaler belongs to the timer or to the watchdog. The fourth is a 3-bit ratio that picks one of eight prescaler taps.

Software reaches the block through one write port and one read port, each addressed by a select bit. Select 0 is the timer value and select 1 is the control register. When the timer rolls over, a sticky overflow flag is set. When the watchdog expires, a one-cycle time-out pulse is raised. The prescaler count itself cannot be read or written. Writing the timer clears the prescaler when the prescaler belongs to the timer. A watchdog clear strobe clears the prescaler when it belongs to the watchdog.

The watchdog's base ticks arrive on `wdt_tick`. The time-out is meant to drive a device reset.

Top module: `tss_shared_timer`

## Requirements
- R1: Reset (synchronous, `rst_n` low) sets the control register to 0xFF. The control fields are: bit 5 source (1 = external level, 0 = one event per cycle), bit 4 edge (1 = falling, 0 = rising), bit 3 owner (1 = watchdog, 0 = timer) and bits 2:0 ratio code n. Bits 7:6 are plain storage. Reading with `rd_sel`=1 returns the control register.
- R2: Reset does not change the timer value. Reading with `rd_sel`=0 returns it.
- R3: With the internal source and the prescaler owned by the watchdog, the timer advances by one on every cycle.
- R4: With the external source, one count event occurs in each cycle in which `ext_lvl` differs from its value in the previous cycle in the selected direction.
- R5: With the prescaler owned by the timer, the timer advances once per 2^(n+1) count events, on the event that completes the group, counting from the last prescaler clear.
- R6: The watchdog counter is `WDT_W` bits wide and advances on `wdt_tick`. When it wraps from all ones, and the prescaler is owned by the timer, `wdt_timeout` pulses in the next cycle. When the prescaler is owned by the watchdog, the pulse comes once per 2^n wraps instead.
- R7: A timer write (`wr_en`=1, `wr_sel`=0) clears the prescaler when the timer owns it. `wdt_clr` leaves a timer-owned prescaler untouched.
- R8: `wdt_clr` clears the watchdog counter. It also clears the prescaler when the watchdog owns it.
- R9: After a timer write, the two following cycles produce no count events. Events in those cycles are dropped and do not reach the prescaler.
- R10: A timer advance from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until `flag_clr` is asserted. A rollover in the same cycle as `flag_clr` wins, and a written value never sets the flag.
- R11: While `wdt_en` is low, the watchdog counter does not advance and `wdt_timeout` stays low.
- R12: A timer write loads `wr_data` and takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 timer, 1 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 timer, 1 control |
| rd_data | output | 8 | Read data |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tick | input | 1 | Watchdog base tick |
| ext_lvl | input | 1 | Synchronized external count level |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
A timer rollover and a software clear of the overflow flag can fall in the same cycle. The bench provokes this by writing 0xFF with the internal source and asserting `flag_clr` exactly in the cycle in which the advance happens. It expects the flag to read set afterwards, and set means the rollover won. A timer write can also coincide with a count event, and a watchdog clear with a watchdog wrap. Both occur in directed form and in the random phase, and they are judged against a cycle model built from the requirements.

// File: rtl/tss_pkg.sv
// Package: shared register width and control-register layout for the
// shared-prescaler timer. Assumes an 8-bit register interface.
package tss_pkg;
    localparam int REG_W = 8;
    localparam int RAT_W = 3;

    typedef struct packed {
        logic [1:0]       spare;     // plain storage
        logic             src_ext;   // 1: external level, 0: per-cycle
        logic             edge_fall; // 1: falling edge counts
        logic             to_wdt;    // 1: prescaler owned by watchdog
        logic [RAT_W-1:0] ratio;     // tap select code
    } ctl_t;
endpackage

// File: rtl/tss_prescaler.sv
// Prescaler: a PS_W-bit up counter advanced by evt. It emits tap for the
// event that completes a group whose size is set by ratio and owner
// (2^(n+1) for the timer, 2^n for the watchdog). A clear wins over an event.
module tss_prescaler #(
    parameter int PS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    evt,
    input  logic                    clr,
    input  logic                    to_wdt,
    input  logic [$clog2(PS_W)-1:0] ratio,
    output logic                    tap
);
    localparam int RAT_W = $clog2(PS_W);

    logic [PS_W-1:0]  cnt;
    logic [PS_W-1:0]  mask;
    logic [RAT_W:0]   span;

    // Number of low bits that must be all ones for a tap.
    assign span = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + 1'b1);

    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (int'(span) > i);
    end

    // Tap fires on the event that completes the selected group.
    assign tap = evt && !clr && ((cnt & mask) == mask);

    // Counter: clear first, then advance on events.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (evt) cnt <= cnt + 1'b1;
    end

    AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R7
    AST_PS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(cnt)); // R5
endmodule

// File: rtl/tss_wdt_counter.sv
// Watchdog counter: WDT_W bits advanced by tick while enabled. It reports
// wrap in the cycle it rolls over from all ones. A clear zeroes it and
// suppresses a wrap in the same cycle.
module tss_wdt_counter #(
    parameter int WDT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic clr,
    output logic wrap
);
    logic [WDT_W-1:0] cnt;

    // Rollover detection, masked by clear.
    assign wrap = en && tick && !clr && (cnt == '1);

    // Counter update: clear has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (en && tick) cnt <= cnt + 1'b1;
    end

    AST_WDT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8
    AST_WDT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt)); // R11
endmodule

// File: rtl/tss_timer_core.sv
// Timer core: the timer register, the post-write hold-off counter and the
// sticky overflow flag. The timer is not reset, so it keeps its value across
// reset. Assumes inc is already gated against hold-off by the caller.
module tss_timer_core #(
    parameter int TMR_W    = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    input  logic             inc,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] value,
    output logic             flag,
    output logic             hold_busy
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [HOLD_W-1:0] hold;
    logic              wrap;

    assign wrap      = inc && !wr && (value == '1);
    assign hold_busy = (hold != '0);

    // Timer register: write beats increment, frozen during reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (wr)       value <= wdata;
            else if (inc) value <= value + 1'b1;
        end
    end

    // Overflow flag: rollover beats software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Hold-off counter: reloaded by a timer write, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold <= '0;
        else if (wr)        hold <= HOLD_W'(HOLD_CYC);
        else if (hold_busy) hold <= hold - 1'b1;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (value == $past(wdata))); // R12
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_busy && !wr) |=> $stable(value)); // R9
    AST_ROLL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(value) == '1 && value == '0 && !$past(wr) && $past(rst_n)) |-> flag); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R10
endmodule

// File: rtl/tss_shared_timer.sv
// Top: the control register, external edge detection, and the routing that
// gives the single prescaler to either the timer or the watchdog. It also
// registers the time-out and provides the read mux. Assumes ext_lvl is
// already synchronized to clk.
module tss_shared_timer #(
    parameter int PS_W     = 8,
    parameter int WDT_W    = 4,
    parameter int HOLD_CYC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [tss_pkg::REG_W-1:0] wr_data,
    input  logic                    rd_sel,
    output logic [tss_pkg::REG_W-1:0] rd_data,
    input  logic                    wdt_clr,
    input  logic                    wdt_en,
    input  logic                    wdt_tick,
    input  logic                    ext_lvl,
    input  logic                    flag_clr,
    output logic                    ovf_flag,
    output logic                    wdt_timeout
);
    import tss_pkg::*;

    ctl_t             ctl;
    logic             ext_prev;
    logic             raw_evt, src_evt, tmr_wr;
    logic             hold_busy, wdt_wrap;
    logic             ps_evt, ps_clr, ps_tap, tmr_inc;
    logic [REG_W-1:0] tmr_value;

    // Control register: all ones on reset, written with select 1.
    always_ff @(posedge clk) begin
        if (!rst_n)                ctl <= ctl_t'('1);
        else if (wr_en && wr_sel)  ctl <= ctl_t'(wr_data);
    end

    // Previous external level for edge detection.
    always_ff @(posedge clk) begin
        ext_prev <= ext_lvl;
    end

    assign tmr_wr  = wr_en && !wr_sel;
    assign raw_evt = ctl.src_ext ? (ctl.edge_fall ? (ext_prev && !ext_lvl)
                                                  : (!ext_prev && ext_lvl))
                                 : 1'b1;
    assign src_evt = raw_evt && !hold_busy && !tmr_wr;

    // Prescaler ownership routing.
    assign ps_evt  = ctl.to_wdt ? wdt_wrap : src_evt;
    assign ps_clr  = ctl.to_wdt ? wdt_clr  : tmr_wr;
    assign tmr_inc = ctl.to_wdt ? src_evt  : ps_tap;

    tss_prescaler #(.PS_W(PS_W)) i_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (ps_evt),
        .clr    (ps_clr),
        .to_wdt (ctl.to_wdt),
        .ratio  (ctl.ratio[$clog2(PS_W)-1:0]),
        .tap    (ps_tap)
    );

    tss_wdt_counter #(.WDT_W(WDT_W)) i_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wdt_en),
        .tick  (wdt_tick),
        .clr   (wdt_clr),
        .wrap  (wdt_wrap)
    );

    tss_timer_core #(.TMR_W(REG_W), .HOLD_CYC(HOLD_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (tmr_wr),
        .wdata     (wr_data),
        .inc       (tmr_inc),
        .flag_clr  (flag_clr),
        .value     (tmr_value),
        .flag      (ovf_flag),
        .hold_busy (hold_busy)
    );

    // Time-out pulse: prescaler tap when watchdog-owned, else raw wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) wdt_timeout <= 1'b0;
        else        wdt_timeout <= ctl.to_wdt ? ps_tap : wdt_wrap;
    end

    assign rd_data = rd_sel ? REG_W'(ctl) : tmr_value;

    AST_TIMEOUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && $past(rst_n)) |-> $past(wdt_en)); // R11
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (REG_W'(ctl) == $past(wr_data))); // R1
endmodule

// File: tb/test_tss_shared_timer.sv
// Bench: directed corner cases and seeded random stimulus, compared each
// cycle with a cycle model written from the requirements.
module test_tss_shared_timer;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, wr_sel, rd_sel, wdt_clr, wdt_en, wdt_tick;
    logic       ext_lvl, flag_clr;
    logic [7:0] wr_data, rd_data;
    logic       ovf_flag, wdt_timeout;

    int n_chk = 0, n_fail = 0;

    // Model state.
    logic [7:0] m_t, m_ps, m_ctrl;
    logic [3:0] m_wc;
    int         m_hold;
    logic       m_flag, m_to, m_prev, m_tvalid;

    always #10 clk = ~clk;

    tss_shared_timer i_tss_shared_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .wdt_clr(wdt_clr), .wdt_en(wdt_en), .wdt_tick(wdt_tick),
        .ext_lvl(ext_lvl), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
        .wdt_timeout(wdt_timeout)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One model cycle using the inputs present before the edge.
    task automatic model_step();
        logic raw, src, to_t, wrap, ps_evt, ps_clr, tap, inc, twr, nxt_to;
        int   span, mask;
        to_t = !m_ctrl[3];
        twr  = wr_en && !wr_sel;
        if (!rst_n) begin
            m_ctrl = 8'hFF; m_ps = 0; m_wc = 0; m_hold = 0;
            m_flag = 0; m_to = 0; m_prev = ext_lvl;
            return;
        end
        raw = m_ctrl[5] ? (m_ctrl[4] ? (m_prev && !ext_lvl) : (!m_prev && ext_lvl)) : 1'b1;
        src = raw && (m_hold == 0) && !twr;
        wrap = wdt_en && wdt_tick && !wdt_clr && (m_wc == 4'hF);
        ps_evt = to_t ? src : wrap;
        ps_clr = to_t ? twr : wdt_clr;
        span = to_t ? int'(m_ctrl[2:0]) + 1 : int'(m_ctrl[2:0]);
        mask = (1 << span) - 1;
        tap = ps_evt && !ps_clr && ((int'(m_ps) & mask) == mask);
        inc = to_t ? tap : src;
        nxt_to = to_t ? wrap : tap;
        if (inc && !twr && m_t == 8'hFF) m_flag = 1;
        else if (flag_clr) m_flag = 0;
        if (twr) begin m_t = wr_data; m_tvalid = 1; end
        else if (inc) m_t = m_t + 1;
        m_hold = twr ? 2 : (m_hold > 0 ? m_hold - 1 : 0);
        if (ps_clr) m_ps = 0; else if (ps_evt) m_ps = m_ps + 1;
        if (wdt_clr) m_wc = 0; else if (wdt_en && wdt_tick) m_wc = m_wc + 1;
        if (wr_en && wr_sel) m_ctrl = wr_data;
        m_to = nxt_to;
        m_prev = ext_lvl;
    endtask

    // Advance one clock and compare the outputs with the model.
    task automatic cyc(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        if (m_tvalid && !rd_sel) chk({req, " timer"}, int'(rd_data), int'(m_t));
        chk({req, " flag"}, int'(ovf_flag), int'(m_flag));
        chk({req, " timeout"}, int'(wdt_timeout), int'(m_to));
        wr_en = 0; wdt_clr = 0; flag_clr = 0;
    endtask

    task automatic wr(string req, logic sel, logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        cyc(req);
    endtask

    task automatic run(string req, int n);
        for (int i = 0; i < n; i++) cyc(req);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed, tos;
        seed = 7;
        void'($urandom(seed));
        m_tvalid = 0; m_t = 0;
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
        wdt_clr = 0; wdt_en = 0; wdt_tick = 0; ext_lvl = 1; flag_clr = 0;
        @(negedge clk);
        run("R1", 3);
        rst_n = 1;
        rd_sel = 1; #1;
        chk("R1 ctrl reset", int'(rd_data), 8'hFF);
        chk("R10 flag reset", int'(ovf_flag), 0);
        rd_sel = 0;

        // R3/R9: internal source, watchdog owns prescaler.
        wr("R1", 1, 8'h08);
        wr("R12", 0, 8'h10);
        chk("R9 load", int'(rd_data), 8'h10);
        cyc("R9"); chk("R9 hold1", int'(rd_data), 8'h10);
        cyc("R9"); chk("R9 hold2", int'(rd_data), 8'h10);
        cyc("R9"); chk("R9 resume", int'(rd_data), 8'h11);
        run("R3", 5); chk("R3 per-cycle", int'(rd_data), 8'h16);

        // R10: rollover, sticky flag, and rollover versus clear.
        wr("R10", 0, 8'hFE);
        run("R10", 4);
        chk("R10 wrapped", int'(rd_data), 8'h00);
        chk("R10 set", int'(ovf_flag), 1);
        run("R10", 3); chk("R10 sticky", int'(ovf_flag), 1);
        flag_clr = 1; cyc("R10"); chk("R10 cleared", int'(ovf_flag), 0);
        wr("R10", 0, 8'hFF);
        chk("R10 write no set", int'(ovf_flag), 0);
        run("R10", 2);
        flag_clr = 1; cyc("R10");
        chk("R10 set beats clear", int'(ovf_flag), 1);
        flag_clr = 1; cyc("R10");

        // R4: external rising, then falling.
        wr("R4", 1, 8'h28);
        for (int i = 0; i < 24; i++) begin ext_lvl = ~ext_lvl; cyc("R4"); cyc("R4"); end
        wr("R4", 1, 8'h38);
        for (int i = 0; i < 24; i++) begin ext_lvl = ~ext_lvl; cyc("R4"); end

        // R5: timer owns the prescaler, internal source, ratio code 1.
        wr("R5", 1, 8'h01);
        wr("R5", 0, 8'h00);
        run("R5", 10);
        chk("R5 div4", int'(rd_data), 2);
        for (int r = 0; r < 8; r++) begin
            wr("R5", 1, 8'(r));
            wr("R5", 0, 8'h00);
            run("R5", 40);
        end

        // R7: timer-owned prescaler, external rising, writes and wdt clears.
        wr("R7", 1, 8'h22);
        wdt_en = 1;
        for (int i = 0; i < 60; i++) begin
            ext_lvl = ~ext_lvl; wdt_tick = 1;
            if (i % 9 == 4) wdt_clr = 1;
            if (i % 17 == 8) begin wr_en = 1; wr_sel = 0; wr_data = 8'(i); end
            cyc("R7");
        end

        // R6/R8: watchdog time-out with and without the prescaler.
        wdt_tick = 1;
        wr("R6", 1, 8'h0A);
        wdt_clr = 1; cyc("R8");
        tos = 0;
        for (int i = 0; i < 140; i++) begin cyc("R6"); tos += int'(wdt_timeout); end
        chk("R6 div4 pulses", tos, 2);
        for (int i = 0; i < 80; i++) begin
            if (i % 30 == 29) wdt_clr = 1;
            cyc("R8");
        end
        wr("R6", 1, 8'h02);
        run("R6", 70);

        // R11: watchdog disabled.
        wdt_en = 0; tos = 0;
        for (int i = 0; i < 100; i++) begin cyc("R11"); tos += int'(wdt_timeout); end
        chk("R11 no timeout", tos, 0);
        wdt_en = 1;

        // R2: timer survives reset.
        ext_lvl = 1;
        wr("R2", 1, 8'h38);
        wr("R2", 0, 8'h5A);
        run("R2", 3);
        rst_n = 0; run("R2", 3); rst_n = 1;
        cyc("R2");
        chk("R2 retained", int'(rd_data), 8'h5A);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            ext_lvl  = 1'($urandom_range(1, 0));
            wdt_tick = ($urandom_range(3, 0) != 0);
            wdt_en   = ($urandom_range(15, 0) != 0);
            wdt_clr  = ($urandom_range(40, 0) == 0);
            flag_clr = ($urandom_range(20, 0) == 0);
            if ($urandom_range(30, 0) == 0) begin
                wr_en = 1; wr_sel = 1'($urandom_range(1, 0));
                wr_data = 8'($urandom_range(255, 0));
            end
            cyc("R12 R10 R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule